// File: doc/BRIEF.md
# Interleaved Multichannel Exponential Smoother

This block applies a first-order low-pass recursion, an exponential moving average, to several independent signals that share one arithmetic datapath. The samples of the signals arrive one per clock in a fixed round-robin order. A frame is one sample from each channel, and a new frame starts on channel 0. The smoothing weight is a power of two, so each update needs only a subtraction, an arithmetic right shift and an addition.

The arithmetic is pipelined over a fixed number of clocks. The result is then sent round a feedback delay line that is sized so the total loop length equals the channel count. A channel's previous output therefore returns to the datapath on the same clock as that channel's next input, and the pipeline registers inside the loop leave the recursion unchanged.

A single enable gates every register. Upstream logic raises the enable for one clock per sample, and the enable may drop for any number of clocks between samples or between frames. The block reports each result together with the index of the channel it belongs to.

Top module: `chan_iir_smoother`

## Requirements
- R1: While reset is high and after it falls, `dout` and `dout_ch` read 0, and every channel's stored state is 0. The first result of each channel is therefore computed from a zero previous output.
- R2: For channel c with previous output p and new input x, the result is p + ((x - p) >>> SHIFT), truncated to DATA_W bits. The shift is arithmetic, so it rounds toward minus infinity; for example, x = -1 with p = 0 and SHIFT = 3 gives -1.
- R3: The input taken on the n-th enabled clock after reset (counting from 0) belongs to channel n mod CHANS. `dout_ch` always stays below CHANS.
- R4: The result for the input taken on enabled clock n appears on `dout` after enabled clock n+ARITH_LAT-1. At that point `dout_ch` reads n mod CHANS. Before ARITH_LAT enabled clocks have passed, `dout` and `dout_ch` read 0.
- R5: On a clock with `en` low, no state changes. `dout` and `dout_ch` hold their values, and `din` has no effect on any later result.
- R6: Each channel's recursion uses only its own previous output. This holds with any pattern of disabled gaps between samples.
- R7: The configuration CHANS = ARITH_LAT, which feeds the result straight back with no added delay stages, follows R2 to R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Sample enable; gates every register |
| din | input | DATA_W | Signed input sample for the current channel slot |
| dout | output | DATA_W | Signed smoothed output |
| dout_ch | output | max(1, clog2(CHANS)) | Channel index of `dout` |

## Verification
If the feedback delay line were one stage too long or too short, each channel would pick up another channel's history. `dout` would then differ from the per-channel model on the first input of the second frame, which is CHANS enabled clocks after reset. A slip in the channel counter or in its delay would show at once as a mismatch between `dout_ch` and the expected index. A register that ignores the enable would corrupt the values that are held through the first disabled gap. The bench compares every output against independent per-channel state on every clock. It does this at full rate, with random gaps, with full-scale values, and on a second configuration that has direct feedback.

// File: rtl/chan_iir_pkg.sv
package chan_iir_pkg;
  localparam int unsigned MIN_ARITH_LAT = 3;

  function automatic int unsigned idx_bits(int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/iir_dly_line.sv
module iir_dly_line #(
  parameter int unsigned W = 16,
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (N == 0) begin : g_wire
      assign q = d;
    end else begin : g_regs
      logic [W-1:0] stg [N];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < N; i++) stg[i] <= '0;
        end else if (en) begin
          stg[0] <= d;
          for (int i = 1; i < N; i++) stg[i] <= stg[i-1];
        end
      end
      assign q = stg[N-1];
    end
  endgenerate
endmodule

// File: rtl/iir_chan_seq.sv
module iir_chan_seq #(
  parameter int unsigned CHANS = 16,
  parameter int unsigned CH_W  = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  output logic [CH_W-1:0] ch
);
  localparam logic [CH_W-1:0] LAST = CH_W'(CHANS - 1);

  always_ff @(posedge clk) begin
    if (rst)        ch <= '0;
    else if (en)    ch <= (ch == LAST) ? '0 : ch + 1'b1;
  end
endmodule

// File: rtl/iir_arith.sv
module iir_arith #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SHIFT  = 3,
  parameter int unsigned LAT    = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic signed [DATA_W-1:0] x,
  input  logic signed [DATA_W-1:0] yprev,
  output logic signed [DATA_W-1:0] y
);
  localparam int unsigned TAIL = LAT - chan_iir_pkg::MIN_ARITH_LAT;

  logic signed [DATA_W:0]   diff_c, diff_q, step_q, sum_c;
  logic signed [DATA_W-1:0] base_q, base2_q, sum_q;
  logic        [DATA_W-1:0] tail_q;

  assign diff_c = $signed({x[DATA_W-1], x}) - $signed({yprev[DATA_W-1], yprev});

  // stage 1: difference and base
  always_ff @(posedge clk) begin
    if (rst) begin
      diff_q <= '0;
      base_q <= '0;
    end else if (en) begin
      diff_q <= diff_c;
      base_q <= yprev;
    end
  end

  // stage 2: weight by power of two
  always_ff @(posedge clk) begin
    if (rst) begin
      step_q  <= '0;
      base2_q <= '0;
    end else if (en) begin
      step_q  <= diff_q >>> SHIFT;
      base2_q <= base_q;
    end
  end

  // stage 3: accumulate
  assign sum_c = $signed({base2_q[DATA_W-1], base2_q}) + step_q;

  always_ff @(posedge clk) begin
    if (rst)      sum_q <= '0;
    else if (en)  sum_q <= sum_c[DATA_W-1:0];
  end

  // extra balancing stages when LAT exceeds the minimum
  iir_dly_line #(.W(DATA_W), .N(TAIL)) u_tail (
    .clk(clk), .rst(rst), .en(en), .d(sum_q), .q(tail_q)
  );

  assign y = $signed(tail_q);
endmodule

// File: rtl/chan_iir_smoother.sv
module chan_iir_smoother #(
  parameter int unsigned CHANS     = 16,
  parameter int unsigned ARITH_LAT = 3,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned SHIFT     = 3,
  parameter int unsigned CH_W      = chan_iir_pkg::idx_bits(CHANS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic signed [DATA_W-1:0] din,
  output logic signed [DATA_W-1:0] dout,
  output logic        [CH_W-1:0]   dout_ch
);
  localparam int unsigned FB_DEPTH = CHANS - ARITH_LAT;

  generate
    if (ARITH_LAT < chan_iir_pkg::MIN_ARITH_LAT || CHANS < ARITH_LAT) begin : g_bad_cfg
      $error("chan_iir_smoother: need CHANS >= ARITH_LAT >= 3");
    end
  endgenerate

  logic        [CH_W-1:0]   in_ch;
  logic signed [DATA_W-1:0] y_res;
  logic        [DATA_W-1:0] fb_q;
  logic signed [DATA_W-1:0] y_prev;
  logic        [CH_W-1:0]   ch_q;

  iir_chan_seq #(.CHANS(CHANS), .CH_W(CH_W)) u_seq (
    .clk(clk), .rst(rst), .en(en), .ch(in_ch)
  );

  iir_arith #(.DATA_W(DATA_W), .SHIFT(SHIFT), .LAT(ARITH_LAT)) u_arith (
    .clk(clk), .rst(rst), .en(en), .x(din), .yprev(y_prev), .y(y_res)
  );

  // loop padding: arithmetic latency + FB_DEPTH = CHANS enabled clocks
  iir_dly_line #(.W(DATA_W), .N(FB_DEPTH)) u_fb (
    .clk(clk), .rst(rst), .en(en), .d(y_res), .q(fb_q)
  );
  assign y_prev = $signed(fb_q);

  iir_dly_line #(.W(CH_W), .N(ARITH_LAT)) u_ch_dly (
    .clk(clk), .rst(rst), .en(en), .d(in_ch), .q(ch_q)
  );

  assign dout    = y_res;
  assign dout_ch = ch_q;
endmodule

// File: rtl/chan_iir_smoother_chk.sv
module chan_iir_smoother_chk #(
  parameter int unsigned CHANS     = 16,
  parameter int unsigned ARITH_LAT = 3,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned CH_W      = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic [DATA_W-1:0] dout,
  input logic [CH_W-1:0]   dout_ch,
  input logic [CH_W-1:0]   in_ch
);
  localparam int unsigned LAG = ARITH_LAT % CHANS;

  int unsigned en_seen;
  logic        primed;
  logic [CH_W-1:0] lag_ch;

  always_ff @(posedge clk) begin
    if (rst)                                 en_seen <= 0;
    else if (en && en_seen < ARITH_LAT)      en_seen <= en_seen + 1;
  end

  assign primed = (en_seen >= ARITH_LAT);
  assign lag_ch = CH_W'((int'(in_ch) + CHANS - LAG) % CHANS);

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(dout) && $stable(dout_ch)));                       // R5
  AST_CH_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    int'(dout_ch) < CHANS);                                             // R3
  AST_CH_STEPS: assert property (@(posedge clk) disable iff (rst)
    (en && primed) |=> (dout_ch == (($past(dout_ch) == CH_W'(CHANS - 1)) ?
                                    '0 : $past(dout_ch) + 1'b1)));      // R3
  AST_CH_LAGS_INPUT: assert property (@(posedge clk) disable iff (rst)
    primed |-> (dout_ch == lag_ch));                                    // R4
  AST_ZERO_UNTIL_FIRST: assert property (@(posedge clk) disable iff (rst)
    !primed |-> (dout == '0 && dout_ch == '0));                         // R1
endmodule

bind chan_iir_smoother chan_iir_smoother_chk #(
  .CHANS(CHANS), .ARITH_LAT(ARITH_LAT), .DATA_W(DATA_W), .CH_W(CH_W)
) u_chk (
  .clk(clk), .rst(rst), .en(en), .dout(dout), .dout_ch(dout_ch), .in_ch(in_ch)
);

// File: tb/chan_iir_smoother_test.sv
module chan_iir_smoother_test;
  localparam int CA = 16, LA = 3, SA = 3;
  localparam int CB = 3,  LB = 3, SB = 2;
  localparam int DW = 16;

  logic clk = 0;
  logic rst = 1;
  logic en  = 0;
  logic signed [DW-1:0] din = '0;
  logic signed [DW-1:0] dout_a, dout_b;
  logic [3:0] ch_a;
  logic [1:0] ch_b;

  always #10 clk = ~clk;

  chan_iir_smoother #(.CHANS(CA), .ARITH_LAT(LA), .DATA_W(DW), .SHIFT(SA)) uut (
    .clk(clk), .rst(rst), .en(en), .din(din), .dout(dout_a), .dout_ch(ch_a)
  );
  chan_iir_smoother #(.CHANS(CB), .ARITH_LAT(LB), .DATA_W(DW), .SHIFT(SB)) uut_direct (
    .clk(clk), .rst(rst), .en(en), .din(din), .dout(dout_b), .dout_ch(ch_b)
  );

  int checks = 0, errors = 0;
  int st_a [CA];
  int st_b [CB];
  int hist_a [64];
  int hist_b [64];
  int ne = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int step(int p, int x, int sh);
    int d;
    d = x - p;
    return p + (d >>> sh);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < CA; i++) st_a[i] = 0;
    for (int i = 0; i < CB; i++) st_b[i] = 0;
    ne = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; en = 1; din = 16'sd1234;
    repeat (3) @(negedge clk);
    rst = 0; en = 0; din = '0;
    model_reset();
    @(posedge clk); #2;
    chk(dout_a == 0, "R1 dout after reset", int'(dout_a), 0);
    chk(ch_a == 0,   "R1 dout_ch after reset", int'(ch_a), 0);
    chk(dout_b == 0, "R1 direct dout after reset", int'(dout_b), 0);
  endtask

  // one clock: drive at negedge, sample 2 ns after the posedge
  task automatic apply(bit en_v, int x_v, string tag);
    int ea, eb, pa, pb, pca;
    pa = int'(dout_a); pb = int'(dout_b); pca = int'(ch_a);
    @(negedge clk);
    en = en_v;
    din = DW'(x_v);
    if (en_v) begin
      ea = ne % CA; eb = ne % CB;
      st_a[ea] = int'($signed(DW'(step(st_a[ea], int'($signed(DW'(x_v))), SA))));
      st_b[eb] = int'($signed(DW'(step(st_b[eb], int'($signed(DW'(x_v))), SB))));
      hist_a[ne % 64] = st_a[ea];
      hist_b[ne % 64] = st_b[eb];
      ne++;
    end
    @(posedge clk); #2;
    if (!en_v) begin
      chk(int'(dout_a) == pa, {tag, " R5 dout held"}, int'(dout_a), pa);
      chk(int'(ch_a) == pca,  {tag, " R5 dout_ch held"}, int'(ch_a), pca);
      chk(int'(dout_b) == pb, {tag, " R5 R7 direct held"}, int'(dout_b), pb);
    end else if (ne >= LA) begin
      chk(int'(dout_a) == hist_a[(ne - LA) % 64], {tag, " R2 R4 R6 dout"},
          int'(dout_a), hist_a[(ne - LA) % 64]);
      chk(int'(ch_a) == (ne - LA) % CA, {tag, " R3 R4 dout_ch"}, int'(ch_a), (ne - LA) % CA);
      chk(int'(dout_b) == hist_b[(ne - LB) % 64], {tag, " R7 direct dout"},
          int'(dout_b), hist_b[(ne - LB) % 64]);
      chk(int'(ch_b) == (ne - LB) % CB, {tag, " R7 direct dout_ch"}, int'(ch_b), (ne - LB) % CB);
    end else begin
      chk(dout_a == 0 && ch_a == 0, {tag, " R4 zero before first result"}, int'(dout_a), 0);
    end
  endtask

  task automatic t_frames_full_rate();
    do_reset();
    for (int f = 0; f < 6; f++)
      for (int c = 0; c < CA; c++)
        apply(1, c * 1500 - 11000 + f * 37, "frames");
    repeat (4) apply(0, 777, "frames");
  endtask

  task automatic t_random_gaps();
    do_reset();
    for (int n = 0; n < 8 * CA; n++) begin
      int g;
      g = int'($urandom_range(0, 4));
      for (int k = 0; k < g; k++) apply(0, int'($urandom_range(0, 65535)) - 32768, "gaps");
      apply(1, int'($urandom_range(0, 65535)) - 32768, "gaps");
    end
  endtask

  task automatic t_negative_floor();
    do_reset();
    for (int c = 0; c < CA; c++) apply(1, -1, "floor");
    for (int c = 0; c < LA; c++) apply(1, 0, "floor");
    // first channel result from zero state with x=-1 is -1 (not 0)
    chk(hist_a[0] == -1, "R2 floor of -1>>>3", hist_a[0], -1);
  endtask

  task automatic t_full_scale();
    do_reset();
    for (int f = 0; f < 10; f++)
      for (int c = 0; c < CA; c++)
        apply(1, ((f + c) % 2 == 0) ? 32767 : -32768, "fullscale");
  endtask

  initial begin
    t_frames_full_rate();
    t_random_gaps();
    t_negative_floor();
    t_full_scale();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule